// File: doc/BRIEF.md
# Fuse Word Auto-Read Sequencer

This block sits between a simple register bus and a one-time-programmable fuse macro and fetches one 32-bit fuse word at a time. Software clears the manual-mode bit, then writes a word address together with a start command. From that point a single counter numbers the cycles of the operation. Each macro pin (chip-select, program-enable, load, address, strobe) is asserted only inside its own start/end cycle window, and every window is held in a timing register that software can change.

The block samples the macro output word in the last cycle of the strobe window. When the longest window has run out, it raises a sticky finish flag and clears the enable bit by itself. A manual mode is also available: the pins then follow a pin-control register directly, and software can read the raw macro output. A second set of timing registers for the programming sequence is stored and can be read back, but the read sequence does not use it.

Top module: `fuse_rd_seq`

## Requirements
- R1: After reset, the mode register (0x00) reads 1 (manual mode). Chip-select and program-enable are high, load and strobe are low, and the finish flag is 0. The read timing registers read chip-select/program-enable/load = {0,11}, address = {2,10}, strobe = {5,8}, and the program chip-select register (0x28) reads {0,1130}. Each timing register holds its start in [31:16] and its end in [15:0].
- R2: In manual mode, the pin register at 0x04 drives the pins directly: bit 0 chip-select, bit 1 strobe, bit 2 load, bit 3 program-enable, address in [15:6]. Offset 0x08 returns the live macro output.
- R3: With manual mode off, a write to 0x10 with bits [1:0] = 11 starts a read of the word address in [25:16]. Bits [1:0] of 0x10 read 11 while the sequence runs and 00 after it. A write with only one of the two bits set starts nothing.
- R4: Cycle 0 is the first cycle after the start write. A pin is active in cycle k exactly when start <= k <= end for its read window. Chip-select and program-enable are active-low. When the block is idle in auto mode, they are high and load and strobe are low.
- R5: The address pins carry the latched word address inside the address window and 0 outside it.
- R6: The data word register (0x18) takes the macro output sampled in the last cycle of the strobe window.
- R7: The finish flag (0x14 bit 0, also finish_o) goes to 1 in cycle max_end+1, where max_end is the largest read window end. It is not set before that cycle, and the enable bit reads 0 from the same cycle.
- R8: Writing 1 to bit 0 of 0x14 clears the finish flag. If that write falls on the same edge that sets the flag, the flag is set.
- R9: A start command written while a sequence runs is ignored. The latched address, the timeline and the captured word all stay unchanged.
- R10: A start command written in manual mode is ignored.
- R11: Rewritten read windows take effect on the next sequence. This covers the sequence length, the strobe placement and the capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| fz_csb_o | output | 1 | Macro chip-select, active low |
| fz_pgenb_o | output | 1 | Macro program-enable, active low |
| fz_load_o | output | 1 | Macro load |
| fz_strobe_o | output | 1 | Macro strobe |
| fz_addr_o | output | 10 | Macro word address |
| fz_dout_i | input | 32 | Macro output word |
| finish_o | output | 1 | Sticky finish flag |

## Verification
The sequence completion and the software clear of the finish flag can land on the same clock edge. The bench provokes this by counting cycles from the start write and placing the write-one-to-clear so that its edge is exactly the one that closes cycle max_end. It then checks that the flag reads 1 in the next cycle. A second collision, a start command issued in the middle of a running sequence, is judged by the unchanged address readback, the unchanged finish cycle and the captured word of the first address.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int FUSE_AW = 10;
  localparam int TFW     = 16;
  localparam int N_WIN   = 5;
  localparam int N_TIM   = 2 * N_WIN;

  localparam int W_CSB   = 0;
  localparam int W_PGENB = 1;
  localparam int W_LOAD  = 2;
  localparam int W_ADDR  = 3;
  localparam int W_STB   = 4;

  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_MAN  = 8'h04;
  localparam logic [7:0] OFS_RAW  = 8'h08;
  localparam logic [7:0] OFS_AUTO = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_WORD = 8'h18;
  localparam logic [7:0] OFS_TIM0 = 8'h28;
  localparam logic [7:0] TIM_SPAN = 8'(4 * (N_TIM - 1));

  // index 0..4 program windows, 5..9 read windows
  function automatic logic [31:0] tim_default(int idx);
    case (idx)
      0, 1, 2, 3: return {16'd0, 16'd1130};
      4:          return {16'd110, 16'd1110};
      5, 6, 7:    return {16'd0, 16'd11};
      8:          return {16'd2, 16'd10};
      default:    return {16'd5, 16'd8};
    endcase
  endfunction
endpackage

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
  import fuse_rd_pkg::*;
#(
  parameter int AW = FUSE_AW
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [7:0]                  addr_i,
  input  logic [31:0]                 wdata_i,
  output logic [31:0]                 rdata_o,
  input  logic                        busy_i,
  input  logic [AW-1:0]               addr_lat_i,
  input  logic                        done_i,
  input  logic                        cap_en_i,
  input  logic [31:0]                 cap_data_i,
  input  logic [31:0]                 raw_i,
  output logic                        user_mode_o,
  output logic                        man_csb_o,
  output logic                        man_stb_o,
  output logic                        man_load_o,
  output logic                        man_pgenb_o,
  output logic [AW-1:0]               man_addr_o,
  output logic [N_WIN-1:0][31:0]      rd_tim_o,
  output logic                        start_req_o,
  output logic [AW-1:0]               start_addr_o,
  output logic                        finish_o
);
  logic [N_TIM-1:0][31:0] tim_q;
  logic [7:0]  tim_off;
  logic        tim_hit;
  logic [5:0]  tim_idx;
  logic        mode_q, finish_q;
  logic [31:0] word_q;
  logic        clr_req;

  assign tim_off = addr_i - OFS_TIM0;
  assign tim_hit = (tim_off <= TIM_SPAN) && (tim_off[1:0] == 2'b00);
  assign tim_idx = tim_off[7:2];

  for (genvar g = 0; g < N_TIM; g++) begin : g_tim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tim_q[g] <= tim_default(g);
      else if (we_i && tim_hit && tim_idx == 6'(g)) tim_q[g] <= wdata_i;
    end
  end

  for (genvar g = 0; g < N_WIN; g++) begin : g_rd
    assign rd_tim_o[g] = tim_q[N_WIN + g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= 1'b1;
      man_csb_o   <= 1'b1;
      man_pgenb_o <= 1'b1;
      man_load_o  <= 1'b0;
      man_stb_o   <= 1'b0;
      man_addr_o  <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_MODE) mode_q <= wdata_i[0];
      if (addr_i == OFS_MAN) begin
        man_csb_o   <= wdata_i[0];
        man_stb_o   <= wdata_i[1];
        man_load_o  <= wdata_i[2];
        man_pgenb_o <= wdata_i[3];
        man_addr_o  <= wdata_i[6 +: AW];
      end
    end
  end

  assign clr_req = we_i && addr_i == OFS_STAT && wdata_i[0];

  // completion wins over a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      finish_q <= 1'b0;
    else if (done_i)  finish_q <= 1'b1;
    else if (clr_req) finish_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        word_q <= '0;
    else if (cap_en_i)  word_q <= cap_data_i;
  end

  assign user_mode_o  = mode_q;
  assign finish_o     = finish_q;
  assign start_req_o  = we_i && addr_i == OFS_AUTO && wdata_i[1:0] == 2'b11 && !mode_q;
  assign start_addr_o = wdata_i[16 +: AW];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_MODE: rdata_o[0] = mode_q;
      OFS_MAN: begin
        rdata_o[0]      = man_csb_o;
        rdata_o[1]      = man_stb_o;
        rdata_o[2]      = man_load_o;
        rdata_o[3]      = man_pgenb_o;
        rdata_o[6 +: AW] = man_addr_o;
      end
      OFS_RAW:  rdata_o = raw_i;
      OFS_AUTO: begin
        rdata_o[1:0]      = {busy_i, busy_i};
        rdata_o[16 +: AW] = addr_lat_i;
      end
      OFS_STAT: rdata_o[0] = finish_q;
      OFS_WORD: rdata_o = word_q;
      default: begin
        for (int i = 0; i < N_TIM; i++)
          if (tim_hit && tim_idx == 6'(i)) rdata_o = tim_q[i];
      end
    endcase
  end

  // R8
  finish_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> finish_q);
endmodule

// File: rtl/fuse_rd_timer.sv
module fuse_rd_timer
  import fuse_rd_pkg::*;
#(
  parameter int AW = FUSE_AW,
  parameter int CW = TFW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_req_i,
  input  logic [AW-1:0]            start_addr_i,
  input  logic [N_WIN-1:0][CW-1:0] end_i,
  output logic                     busy_o,
  output logic [CW-1:0]            cnt_o,
  output logic [AW-1:0]            addr_lat_o,
  output logic                     done_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q, max_end;
  logic [AW-1:0] addr_q;

  always_comb begin
    max_end = '0;
    for (int i = 0; i < N_WIN; i++)
      if (end_i[i] > max_end) max_end = end_i[i];
  end

  assign done_o = busy_q && cnt_q == max_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (!busy_q) begin
      if (start_req_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        addr_q <= start_addr_i;
      end
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign cnt_o      = cnt_q;
  assign addr_lat_o = addr_q;

  // R7
  end_at_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == $past(max_end));
  // R9
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_req_i |=> $stable(addr_q));
endmodule

// File: rtl/fuse_rd_pins.sv
module fuse_rd_pins
  import fuse_rd_pkg::*;
#(
  parameter int AW = FUSE_AW,
  parameter int CW = TFW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  user_mode_i,
  input  logic                  busy_i,
  input  logic [CW-1:0]         cnt_i,
  input  logic [N_WIN-1:0][31:0] tim_i,
  input  logic [AW-1:0]         addr_lat_i,
  input  logic                  man_csb_i,
  input  logic                  man_stb_i,
  input  logic                  man_load_i,
  input  logic                  man_pgenb_i,
  input  logic [AW-1:0]         man_addr_i,
  output logic                  fz_csb_o,
  output logic                  fz_pgenb_o,
  output logic                  fz_load_o,
  output logic                  fz_strobe_o,
  output logic [AW-1:0]         fz_addr_o,
  output logic                  cap_en_o
);
  logic [N_WIN-1:0] act;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    assign act[g] = busy_i && cnt_i >= tim_i[g][16 +: CW] && cnt_i <= tim_i[g][0 +: CW];
  end

  assign cap_en_o = act[W_STB] && cnt_i == tim_i[W_STB][0 +: CW];

  always_comb begin
    if (user_mode_i) begin
      fz_csb_o    = man_csb_i;
      fz_pgenb_o  = man_pgenb_i;
      fz_load_o   = man_load_i;
      fz_strobe_o = man_stb_i;
      fz_addr_o   = man_addr_i;
    end else begin
      fz_csb_o    = !act[W_CSB];
      fz_pgenb_o  = !act[W_PGENB];
      fz_load_o   = act[W_LOAD];
      fz_strobe_o = act[W_STB];
      fz_addr_o   = act[W_ADDR] ? addr_lat_i : '0;
    end
  end

  // R4
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !user_mode_i && !busy_i |-> fz_csb_o && fz_pgenb_o && !fz_load_o && !fz_strobe_o);
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int AW = FUSE_AW,
  parameter int CW = TFW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [7:0]    bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  output logic          fz_csb_o,
  output logic          fz_pgenb_o,
  output logic          fz_load_o,
  output logic          fz_strobe_o,
  output logic [AW-1:0] fz_addr_o,
  input  logic [31:0]   fz_dout_i,
  output logic          finish_o
);
  logic                     user_mode, busy, done, cap_en, start_req;
  logic                     man_csb, man_stb, man_load, man_pgenb;
  logic [AW-1:0]            man_addr, addr_lat, start_addr;
  logic [CW-1:0]            cnt;
  logic [N_WIN-1:0][31:0]   rd_tim;
  logic [N_WIN-1:0][CW-1:0] win_end;

  for (genvar g = 0; g < N_WIN; g++) begin : g_end
    assign win_end[g] = rd_tim[g][0 +: CW];
  end

  fuse_rd_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .busy_i(busy), .addr_lat_i(addr_lat), .done_i(done),
    .cap_en_i(cap_en), .cap_data_i(fz_dout_i), .raw_i(fz_dout_i),
    .user_mode_o(user_mode), .man_csb_o(man_csb), .man_stb_o(man_stb),
    .man_load_o(man_load), .man_pgenb_o(man_pgenb), .man_addr_o(man_addr),
    .rd_tim_o(rd_tim), .start_req_o(start_req), .start_addr_o(start_addr),
    .finish_o(finish_o)
  );

  fuse_rd_timer #(.AW(AW), .CW(CW)) u_timer (
    .clk_i, .rst_ni,
    .start_req_i(start_req), .start_addr_i(start_addr), .end_i(win_end),
    .busy_o(busy), .cnt_o(cnt), .addr_lat_o(addr_lat), .done_o(done)
  );

  fuse_rd_pins #(.AW(AW), .CW(CW)) u_pins (
    .clk_i, .rst_ni,
    .user_mode_i(user_mode), .busy_i(busy), .cnt_i(cnt), .tim_i(rd_tim),
    .addr_lat_i(addr_lat), .man_csb_i(man_csb), .man_stb_i(man_stb),
    .man_load_i(man_load), .man_pgenb_i(man_pgenb), .man_addr_i(man_addr),
    .fz_csb_o, .fz_pgenb_o, .fz_load_o, .fz_strobe_o, .fz_addr_o,
    .cap_en_o(cap_en)
  );

  // R6
  capture_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en && !user_mode |-> fz_strobe_o);
  // R10
  start_only_auto_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !$past(user_mode));
endmodule

// File: tb/fuse_rd_seq_tb.sv
module fuse_rd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        csb, pgenb, load, stb, fin;
  logic [9:0]  faddr;
  logic [31:0] fdout;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] fw(logic [9:0] a);
    return {~a, 6'h15, a, 6'h2a};
  endfunction

  assign fdout = (stb && !csb) ? fw(faddr) : 32'h0;

  fuse_rd_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fz_csb_o(csb),
    .fz_pgenb_o(pgenb), .fz_load_o(load), .fz_strobe_o(stb),
    .fz_addr_o(faddr), .fz_dout_i(fdout), .finish_o(fin)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    #1;
    chk("R1 csb", csb, 1); chk("R1 pgenb", pgenb, 1);
    chk("R1 load", load, 0); chk("R1 strobe", stb, 0); chk("R1 finish", fin, 0);
    rd(8'h00, d); chk("R1 mode", d, 32'h1);
    rd(8'h4C, d); chk("R1 strobe window", d, {16'd5, 16'd8});
    rd(8'h48, d); chk("R1 addr window", d, {16'd2, 16'd10});
    rd(8'h3C, d); chk("R1 csb window", d, {16'd0, 16'd11});
    rd(8'h28, d); chk("R1 prog csb window", d, {16'd0, 16'd1130});
  endtask

  task automatic t_user();
    logic [31:0] d;
    wr(8'h04, (32'h155 << 6) | 32'hC);
    #1;
    chk("R2 csb", csb, 0); chk("R2 pgenb", pgenb, 1); chk("R2 load", load, 1);
    chk("R2 strobe", stb, 0); chk("R2 addr", faddr, 10'h155);
    @(negedge clk);
    wr(8'h04, (32'h155 << 6) | 32'hE);
    #1 chk("R2 strobe on", stb, 1);
    rd(8'h08, d); chk("R2 raw out", d, fw(10'h155));
    @(negedge clk);
    wr(8'h00, 32'h0);
    #1;
    chk("R4 idle csb", csb, 1); chk("R4 idle pgenb", pgenb, 1);
    chk("R4 idle load", load, 0); chk("R4 idle addr", faddr, 0);
  endtask

  task automatic t_no_start();
    logic [31:0] d;
    @(negedge clk);
    wr(8'h10, (32'h11 << 16) | 32'h2);
    rd(8'h10, d); chk("R3 half cmd no start", d[1:0], 0);
    chk("R3 half cmd pins", csb, 1);
  endtask

  task automatic t_default(logic [9:0] a);
    logic [31:0] d;
    int bad;
    @(negedge clk);
    wr(8'h10, (32'(a) << 16) | 32'h3);
    bad = 0;
    for (int k = 0; k <= 13; k++) begin
      #1;
      if (csb !== !(k <= 11)) bad++;
      if (pgenb !== !(k <= 11)) bad++;
      if (load !== (k <= 11)) bad++;
      if (stb !== (k >= 5 && k <= 8)) bad++;
      if (faddr !== ((k >= 2 && k <= 10) ? a : 10'h0)) bad++;
      if (k == 3) begin rd(8'h10, d); chk("R3 busy readback", d, (32'(a) << 16) | 32'h3); end
      if (k == 11) chk("R7 no early finish", fin, 0);
      if (k == 12) begin
        chk("R7 finish at max_end+1", fin, 1);
        rd(8'h10, d); chk("R7 enable self-clear", d[1:0], 0);
        rd(8'h18, d); chk("R6 captured word", d, fw(a));
      end
      @(negedge clk);
    end
    chk("R4 R5 window pins", bad, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(8'h14, 32'h1);
    rd(8'h14, d); chk("R8 w1c clears", d, 0);
  endtask

  task automatic t_busy_start();
    logic [31:0] d;
    @(negedge clk);
    wr(8'h10, (32'h2C1 << 16) | 32'h3);
    repeat (3) @(negedge clk);
    wr(8'h10, (32'h0F0 << 16) | 32'h3);
    rd(8'h10, d); chk("R9 address held", d[25:16], 10'h2C1);
    repeat (7) @(negedge clk);
    #1 chk("R9 timeline kept (cyc11)", fin, 0);
    @(negedge clk);
    #1 chk("R9 finish at cyc12", fin, 1);
    rd(8'h18, d); chk("R9 word of first addr", d, fw(10'h2C1));
    @(negedge clk);
    wr(8'h14, 32'h1);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk);
    wr(8'h10, (32'h3A5 << 16) | 32'h3);
    repeat (10) @(negedge clk);
    wr(8'h14, 32'h1);          // edge closing cycle 10: nothing to clear
    #1 chk("R8 clear before set", fin, 0);
    wr(8'h14, 32'h1);          // edge closing cycle 11: set and clear together
    #1 chk("R8 set wins", fin, 1);
    wr(8'h14, 32'h1);
    rd(8'h14, d); chk("R8 later clear", d, 0);
  endtask

  task automatic t_user_start();
    logic [31:0] d;
    @(negedge clk);
    wr(8'h00, 32'h1);
    wr(8'h10, (32'h77 << 16) | 32'h3);
    rd(8'h10, d); chk("R10 no busy in manual", d[1:0], 0);
    repeat (15) @(negedge clk);
    #1 chk("R10 no finish in manual", fin, 0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_custom(logic [9:0] a);
    logic [31:0] d;
    int bad;
    @(negedge clk);
    wr(8'h4C, {16'd3, 16'd20});
    wr(8'h48, {16'd1, 16'd21});
    wr(8'h3C, {16'd0, 16'd22});
    wr(8'h10, (32'(a) << 16) | 32'h3);
    bad = 0;
    for (int k = 0; k <= 23; k++) begin
      #1;
      if (stb !== (k >= 3 && k <= 20)) bad++;
      if (csb !== !(k <= 22)) bad++;
      if (load !== (k <= 11)) bad++;
      if (faddr !== ((k >= 1 && k <= 21) ? a : 10'h0)) bad++;
      if (k == 22) chk("R11 no finish at 22", fin, 0);
      if (k == 23) begin
        chk("R11 finish at 23", fin, 1);
        rd(8'h18, d); chk("R11 word", d, fw(a));
      end
      @(negedge clk);
    end
    chk("R11 custom windows", bad, 0);
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    t_user();
    t_no_start();
    t_default(10'h2A7);
    t_w1c();
    t_default(10'h00C);
    t_w1c();
    t_busy_start();
    t_collide();
    t_user_start();
    t_custom(10'h1E3);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule